// File: doc/BRIEF.md
# Switch Port Packet Steering Unit

This block makes the forwarding decision for one port of a packet switch. It takes the header fields of one incoming transaction at a time and chooses where the packet goes. The fields are the packet kind, a 64-bit physical target address, a 16-bit bus/device/function identifier and the ingress port. Port 0 is the upstream port, the one toward the root. Ports 1 to N_DN are downstream ports. The verdict is one of three: forward to a named downstream port, send upstream, or drop. A dropped packet carries a flag that gives the cause.

Memory requests are steered by a programmable table of address windows. Each window holds an inclusive address range, a target port and a valid bit. Identifier-routed packets are steered by a bus/device/function range that each downstream port owns. Each downstream port also carries two access-control bits. One blocks traffic from that port that would go peer-to-peer. The other forces such traffic upstream. The tables are loaded through a write-only register port.

The decision is computed from the header together with the table contents at the cycle the header is accepted. It appears one cycle after a valid/ready handshake and is held until the consumer accepts it.

Top module: `pkt_route_unit`

## Requirements
- R1: An address-routed header (`hdr_kind`=0) whose address falls inside a valid window is forwarded (verdict 0) to that window's target port, if the target is a downstream port other than the ingress port.
- R2: When several valid windows contain the address, the window with the lowest index decides. When several downstream ID ranges contain the identifier, the lowest-numbered port decides.
- R3: An address-routed header from a downstream port that matches no valid window gets verdict 1 (upstream). After reset no window is valid, so every memory packet from a downstream port goes upstream. A window whose target is port 0 also gives verdict 1.
- R4: An ID-routed header (`hdr_kind`=1) goes to the lowest downstream port whose valid range [lo, hi] contains `hdr_id`. An ID-routed header from a downstream port that matches no range goes upstream.
- R5: A header from downstream port p that would be forwarded to another downstream port is checked against the access-control bits of p. If the block bit is set, the packet is dropped (verdict 2) with `dec_blk`. Otherwise, if the force bit is set, it goes upstream. The block bit wins over the force bit. The rule applies to both packet kinds and has no effect on packets whose target is upstream.
- R6: A header whose selected target equals its own ingress port is dropped (verdict 2) with `dec_loop`. This covers a window with target 0 hit from port 0.
- R7: A header from the upstream port that matches no window (address kind) or no range (ID kind) is dropped (verdict 2) with `dec_ur`. A header from port 0 never gets verdict 1.
- R8: A header is accepted on a clock edge where `hdr_valid` and `hdr_ready` are both high. The decision is valid from that edge, with `dec_valid` high. While `dec_valid` is high and `dec_ready` is low, the decision stays unchanged and `hdr_ready` is low.
- R9: A register write (`cfg_we`) takes `cfg_addr[7:6]` as the table and `cfg_addr[5:0]` as the entry. Table 0 is the window base. Table 1 is the window limit. Table 2 is window control: target in bits [2:0], valid in bit 8. Table 3 is the settings of downstream port entry+1: lo in [15:0], hi in [31:16], range valid in 32, block in 33, force in 34. Clearing a valid bit removes the entry from the decision.
- R10: Window ranges are inclusive at both ends: the base and limit addresses match, and base-1 and limit+1 do not.
- R11: For verdicts 1 and 2, `dec_port` reads 0, and exactly one of `dec_loop`, `dec_ur`, `dec_blk` is high only on verdict 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 8 | Table select [7:6] and entry index [5:0] |
| cfg_wdata | input | 64 | Write data |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header can be accepted |
| hdr_kind | input | 1 | 0 address-routed memory request, 1 ID-routed |
| hdr_addr | input | 64 | Physical target address |
| hdr_id | input | 16 | Target bus/device/function |
| hdr_port | input | 3 | Ingress port, 0 = upstream |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_verdict | output | 2 | 0 forward, 1 upstream, 2 drop |
| dec_port | output | 3 | Egress downstream port for verdict 0 |
| dec_loop | output | 1 | Drop cause: target is the ingress port |
| dec_ur | output | 1 | Drop cause: unclaimed request from upstream |
| dec_blk | output | 1 | Drop cause: access-control block |

## Verification
The assertions take for granted that `hdr_port` never exceeds N_DN and that every programmed window target names an existing port. The assertion on forwarded ports depends on this. They also assume that a consumer holding `dec_ready` low does not need the header path to be frozen, because the block itself lowers `hdr_ready`. The stimulus uses only ports 0 to 4 and targets 0 to 4. It drives all inputs on the falling edge. It changes the tables only while no header is being offered.

// File: rtl/pkt_route_pkg.sv
// Package: shared verdict encoding and table-select codes for the steering unit.
// Assumes: consumers use the 2-bit verdict as driven on dec_verdict.
package pkt_route_pkg;

    typedef enum logic [1:0] {
        VERD_FWD  = 2'd0,
        VERD_UP   = 2'd1,
        VERD_DROP = 2'd2
    } verdict_e;

    localparam logic [1:0] SEL_BASE  = 2'd0;
    localparam logic [1:0] SEL_LIMIT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_PORT  = 2'd3;

    localparam int CTRL_VLD_BIT = 8;
    localparam int PORT_VLD_BIT = 32;
    localparam int PORT_BLK_BIT = 33;
    localparam int PORT_FRC_BIT = 34;

endpackage

// File: rtl/route_cfg_regs.sv
// Table storage: address windows and the per-downstream-port ID range and
// access-control bits, written through a simple strobe interface.
// Assumes: DATA_W >= 35 and >= ADDR_W; index field of cfg_addr is 6 bits.
module route_cfg_regs
    import pkt_route_pkg::*;
#(
    parameter int N_WIN  = 8,
    parameter int N_DN   = 4,
    parameter int ADDR_W = 64,
    parameter int ID_W   = 16,
    parameter int PORT_W = 3,
    parameter int DATA_W = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [7:0]                     cfg_addr,
    input  logic [DATA_W-1:0]              cfg_wdata,
    output logic [N_WIN-1:0][ADDR_W-1:0]   win_base,
    output logic [N_WIN-1:0][ADDR_W-1:0]   win_lim,
    output logic [N_WIN-1:0][PORT_W-1:0]   win_tgt,
    output logic [N_WIN-1:0]               win_vld,
    output logic [N_DN-1:0][ID_W-1:0]      id_lo,
    output logic [N_DN-1:0][ID_W-1:0]      id_hi,
    output logic [N_DN-1:0]                id_vld,
    output logic [N_DN-1:0]                acs_blk,
    output logic [N_DN-1:0]                acs_frc
);

    logic [1:0] sel;
    logic [5:0] idx;
    assign sel = cfg_addr[7:6];
    assign idx = cfg_addr[5:0];

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        // Update one window entry on a matching write; reset invalidates it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_base[w] <= '0;
                win_lim[w]  <= '0;
                win_tgt[w]  <= '0;
                win_vld[w]  <= 1'b0;
            end else if (cfg_we && idx == 6'(w)) begin
                if (sel == SEL_BASE)  win_base[w] <= cfg_wdata[ADDR_W-1:0];
                if (sel == SEL_LIMIT) win_lim[w]  <= cfg_wdata[ADDR_W-1:0];
                if (sel == SEL_CTRL) begin
                    win_tgt[w] <= cfg_wdata[PORT_W-1:0];
                    win_vld[w] <= cfg_wdata[CTRL_VLD_BIT];
                end
            end
        end
    end

    for (genvar p = 0; p < N_DN; p++) begin : g_dn
        // Update one downstream port's range and policy; reset clears all.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                id_lo[p]   <= '0;
                id_hi[p]   <= '0;
                id_vld[p]  <= 1'b0;
                acs_blk[p] <= 1'b0;
                acs_frc[p] <= 1'b0;
            end else if (cfg_we && sel == SEL_PORT && idx == 6'(p)) begin
                id_lo[p]   <= cfg_wdata[ID_W-1:0];
                id_hi[p]   <= cfg_wdata[2*ID_W-1:ID_W];
                id_vld[p]  <= cfg_wdata[PORT_VLD_BIT];
                acs_blk[p] <= cfg_wdata[PORT_BLK_BIT];
                acs_frc[p] <= cfg_wdata[PORT_FRC_BIT];
            end
        end
    end

endmodule

// File: rtl/route_win_match.sv
// Address window decode: compares the packet address with every valid
// window (inclusive bounds) and reports the lowest-index hit.
// Assumes: base <= limit for windows meant to match anything.
module route_win_match #(
    parameter int N_WIN  = 8,
    parameter int ADDR_W = 64,
    parameter int PORT_W = 3
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [N_WIN-1:0][ADDR_W-1:0]  win_base,
    input  logic [N_WIN-1:0][ADDR_W-1:0]  win_lim,
    input  logic [N_WIN-1:0][PORT_W-1:0]  win_tgt,
    input  logic [N_WIN-1:0]              win_vld,
    output logic                          hit,
    output logic [PORT_W-1:0]             tgt
);

    logic [N_WIN-1:0] in_range;

    for (genvar w = 0; w < N_WIN; w++) begin : g_cmp
        assign in_range[w] = win_vld[w] && (addr >= win_base[w]) && (addr <= win_lim[w]);
    end

    // Priority pick: scan from the top so the lowest index is written last.
    always_comb begin
        hit = 1'b0;
        tgt = '0;
        for (int w = N_WIN - 1; w >= 0; w--) begin
            if (in_range[w]) begin
                hit = 1'b1;
                tgt = win_tgt[w];
            end
        end
    end

endmodule

// File: rtl/route_id_match.sv
// Identifier decode: finds the lowest downstream port whose valid range
// contains the packet identifier; port numbers start at 1.
// Assumes: N_DN + 1 fits in PORT_W bits.
module route_id_match #(
    parameter int N_DN   = 4,
    parameter int ID_W   = 16,
    parameter int PORT_W = 3
) (
    input  logic [ID_W-1:0]             id,
    input  logic [N_DN-1:0][ID_W-1:0]   id_lo,
    input  logic [N_DN-1:0][ID_W-1:0]   id_hi,
    input  logic [N_DN-1:0]             id_vld,
    output logic                        hit,
    output logic [PORT_W-1:0]           port
);

    logic [N_DN-1:0] in_range;

    for (genvar p = 0; p < N_DN; p++) begin : g_cmp
        assign in_range[p] = id_vld[p] && (id >= id_lo[p]) && (id <= id_hi[p]);
    end

    // Priority pick of the lowest-numbered claiming port.
    always_comb begin
        hit  = 1'b0;
        port = '0;
        for (int p = N_DN - 1; p >= 0; p--) begin
            if (in_range[p]) begin
                hit  = 1'b1;
                port = PORT_W'(p + 1);
            end
        end
    end

endmodule

// File: rtl/route_policy.sv
// Verdict logic: turns a match result into forward/upstream/drop, applying
// the self-target check, the upstream-unclaimed rule and access control.
// Assumes: ingress <= N_DN; port 0 is the upstream port.
module route_policy
    import pkt_route_pkg::*;
#(
    parameter int N_DN   = 4,
    parameter int PORT_W = 3
) (
    input  logic [PORT_W-1:0]  ingress,
    input  logic               hit,
    input  logic [PORT_W-1:0]  tgt,
    input  logic [N_DN-1:0]    acs_blk,
    input  logic [N_DN-1:0]    acs_frc,
    output verdict_e           verdict,
    output logic [PORT_W-1:0]  egress,
    output logic               loop,
    output logic               ur,
    output logic               blk
);

    localparam int NPORT = N_DN + 1;

    logic [NPORT-1:0] blk_all;
    logic [NPORT-1:0] frc_all;
    logic             from_up;
    assign blk_all = {acs_blk, 1'b0};
    assign frc_all = {acs_frc, 1'b0};
    assign from_up = (ingress == '0);

    // Decide the verdict in priority order: unclaimed, self, upstream, policy.
    always_comb begin
        verdict = VERD_DROP;
        egress  = '0;
        loop    = 1'b0;
        ur      = 1'b0;
        blk     = 1'b0;
        if (!hit) begin
            if (from_up) ur = 1'b1;
            else         verdict = VERD_UP;
        end else if (tgt == ingress) begin
            loop = 1'b1;
        end else if (tgt == '0) begin
            verdict = VERD_UP;
        end else if (!from_up && blk_all[ingress]) begin
            blk = 1'b1;
        end else if (!from_up && frc_all[ingress]) begin
            verdict = VERD_UP;
        end else begin
            verdict = VERD_FWD;
            egress  = tgt;
        end
    end

endmodule

// File: rtl/pkt_route_unit.sv
// Top: accepts one header per handshake, decodes it against the tables and
// registers the verdict, holding it until the consumer takes it.
// Assumes: hdr_port <= N_DN and window targets name existing ports.
module pkt_route_unit
    import pkt_route_pkg::*;
#(
    parameter int N_DN   = 4,
    parameter int N_WIN  = 8,
    parameter int ADDR_W = 64,
    parameter int ID_W   = 16,
    localparam int PORT_W = $clog2(N_DN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_addr,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic               hdr_valid,
    output logic               hdr_ready,
    input  logic               hdr_kind,
    input  logic [ADDR_W-1:0]  hdr_addr,
    input  logic [ID_W-1:0]    hdr_id,
    input  logic [PORT_W-1:0]  hdr_port,
    output logic               dec_valid,
    input  logic               dec_ready,
    output logic [1:0]         dec_verdict,
    output logic [PORT_W-1:0]  dec_port,
    output logic               dec_loop,
    output logic               dec_ur,
    output logic               dec_blk
);

    logic [N_WIN-1:0][ADDR_W-1:0] win_base, win_lim;
    logic [N_WIN-1:0][PORT_W-1:0] win_tgt;
    logic [N_WIN-1:0]             win_vld;
    logic [N_DN-1:0][ID_W-1:0]    id_lo, id_hi;
    logic [N_DN-1:0]              id_vld, acs_blk, acs_frc;

    logic              w_hit, i_hit, sel_hit;
    logic [PORT_W-1:0] w_tgt, i_port, sel_tgt, nx_port;
    logic              nx_loop, nx_ur, nx_blk;
    verdict_e          nx_verd, verd_q;
    logic              take;

    route_cfg_regs #(
        .N_WIN(N_WIN), .N_DN(N_DN), .ADDR_W(ADDR_W),
        .ID_W(ID_W), .PORT_W(PORT_W), .DATA_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .win_base(win_base), .win_lim(win_lim),
        .win_tgt(win_tgt), .win_vld(win_vld), .id_lo(id_lo), .id_hi(id_hi),
        .id_vld(id_vld), .acs_blk(acs_blk), .acs_frc(acs_frc)
    );

    route_win_match #(.N_WIN(N_WIN), .ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_win (
        .addr(hdr_addr), .win_base(win_base), .win_lim(win_lim),
        .win_tgt(win_tgt), .win_vld(win_vld), .hit(w_hit), .tgt(w_tgt)
    );

    route_id_match #(.N_DN(N_DN), .ID_W(ID_W), .PORT_W(PORT_W)) u_id (
        .id(hdr_id), .id_lo(id_lo), .id_hi(id_hi), .id_vld(id_vld),
        .hit(i_hit), .port(i_port)
    );

    assign sel_hit = hdr_kind ? i_hit  : w_hit;
    assign sel_tgt = hdr_kind ? i_port : w_tgt;

    route_policy #(.N_DN(N_DN), .PORT_W(PORT_W)) u_pol (
        .ingress(hdr_port), .hit(sel_hit), .tgt(sel_tgt),
        .acs_blk(acs_blk), .acs_frc(acs_frc), .verdict(nx_verd),
        .egress(nx_port), .loop(nx_loop), .ur(nx_ur), .blk(nx_blk)
    );

    assign hdr_ready = !dec_valid || dec_ready;
    assign take      = hdr_valid && hdr_ready;

    // Output register: load on accept, clear once taken, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            verd_q    <= VERD_DROP;
            dec_port  <= '0;
            dec_loop  <= 1'b0;
            dec_ur    <= 1'b0;
            dec_blk   <= 1'b0;
        end else if (take) begin
            dec_valid <= 1'b1;
            verd_q    <= nx_verd;
            dec_port  <= nx_port;
            dec_loop  <= nx_loop;
            dec_ur    <= nx_ur;
            dec_blk   <= nx_blk;
        end else if (dec_ready) begin
            dec_valid <= 1'b0;
        end
    end

    assign dec_verdict = verd_q;

    AST_ACCEPT_TO_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_ready |=> dec_valid);                                  // R8
    AST_HOLD_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !dec_ready |=> dec_valid && $stable(dec_verdict) && $stable(dec_port)); // R8
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !dec_ready |-> !hdr_ready);                                // R8
    AST_NO_UPSTREAM_BOUNCE: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_ready && hdr_port == '0 |=> dec_verdict != 2'd1);      // R7
    AST_NO_SELF_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_ready |=> !(dec_verdict == 2'd0 && dec_port == $past(hdr_port))); // R6
    AST_DROP_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_verdict == 2'd2) == ($countones({dec_loop, dec_ur, dec_blk}) == 1)); // R11
    AST_FWD_DOWNSTREAM: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_verdict == 2'd0 |-> dec_port != '0 && dec_port <= PORT_W'(N_DN)); // R1

endmodule

// File: tb/test_pkt_route_unit.sv
module test_pkt_route_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic        hdr_kind = 1'b0;
    logic [63:0] hdr_addr = '0;
    logic [15:0] hdr_id = '0;
    logic [2:0]  hdr_port = '0;
    logic        dec_valid;
    logic        dec_ready = 1'b1;
    logic [1:0]  dec_verdict;
    logic [2:0]  dec_port;
    logic        dec_loop, dec_ur, dec_blk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [1:0] FWD = 2'd0, UP = 2'd1, DROP = 2'd2;
    localparam logic [63:0] HOST = 64'h8000_0000_0000_0000;

    always #10 clk = ~clk;

    pkt_route_unit i_pkt_route_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_kind(hdr_kind), .hdr_addr(hdr_addr), .hdr_id(hdr_id),
        .hdr_port(hdr_port), .dec_valid(dec_valid), .dec_ready(dec_ready),
        .dec_verdict(dec_verdict), .dec_port(dec_port), .dec_loop(dec_loop),
        .dec_ur(dec_ur), .dec_blk(dec_blk)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int idx, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {sel, 6'(idx)}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_win(input int w, input logic [63:0] b, input logic [63:0] l,
                           input logic [2:0] t, input bit v);
        wr(2'd0, w, b);
        wr(2'd1, w, l);
        wr(2'd2, w, {55'd0, v, 5'd0, t});
    endtask

    task automatic set_port(input int p, input logic [15:0] lo, input logic [15:0] hi,
                            input bit v, input bit b, input bit f);
        wr(2'd3, p - 1, {29'd0, f, b, v, hi, lo});
    endtask

    // One header through the unit; decision sampled on the falling edge after accept.
    task automatic route(input string req, input bit kind, input logic [63:0] a,
                         input logic [15:0] id, input logic [2:0] port,
                         input logic [1:0] ev, input logic [2:0] ep,
                         input bit el, input bit eu, input bit eb);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_kind = kind; hdr_addr = a; hdr_id = id; hdr_port = port;
        @(negedge clk);
        hdr_valid = 1'b0;
        check({req, " valid"}, 32'(dec_valid), 32'd1);
        check({req, " verdict"}, 32'(dec_verdict), 32'(ev));
        check({req, " port"}, 32'(dec_port), 32'(ep));
        check({req, " flags"}, 32'({dec_loop, dec_ur, dec_blk}), 32'({el, eu, eb}));
    endtask

    task automatic t_reset;
        check("R8 reset dec_valid", 32'(dec_valid), 32'd0);
        check("R8 reset hdr_ready", 32'(hdr_ready), 32'd1);
    endtask

    task automatic t_empty;
        route("R3 empty mem", 0, 64'h1000_0000, 16'h0, 3'd1, UP, 3'd0, 0, 0, 0);
        route("R4 empty id", 1, 64'h0, 16'h0220, 3'd2, UP, 3'd0, 0, 0, 0);
        route("R7 empty from up", 0, 64'h1000_0000, 16'h0, 3'd0, DROP, 3'd0, 0, 1, 0);
    endtask

    task automatic t_config;
        set_win(0, 64'h1000_0000, 64'h1FFF_FFFF, 3'd2, 1);
        set_win(1, 64'h1800_0000, 64'h2FFF_FFFF, 3'd3, 1);
        set_win(2, HOST, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 1);
        set_win(5, 64'h4000, 64'h4FFF, 3'd1, 1);
        set_port(1, 16'h0100, 16'h01FF, 1, 0, 0);
        set_port(2, 16'h0200, 16'h02FF, 1, 0, 0);
        set_port(3, 16'h0150, 16'h0250, 1, 0, 0);
    endtask

    task automatic t_address;
        route("R1 R10 base", 0, 64'h1000_0000, 16'h0, 3'd1, FWD, 3'd2, 0, 0, 0);
        route("R10 limit", 0, 64'h1FFF_FFFF, 16'h0, 3'd1, FWD, 3'd2, 0, 0, 0);
        route("R10 base-1", 0, 64'h0FFF_FFFF, 16'h0, 3'd1, UP, 3'd0, 0, 0, 0);
        route("R1 second win", 0, 64'h2000_0000, 16'h0, 3'd1, FWD, 3'd3, 0, 0, 0);
        route("R2 overlap", 0, 64'h1800_0000, 16'h0, 3'd4, FWD, 3'd2, 0, 0, 0);
        route("R1 from up", 0, 64'h4800, 16'h0, 3'd0, FWD, 3'd1, 0, 0, 0);
        route("R3 host win", 0, HOST + 64'h5, 16'h0, 3'd1, UP, 3'd0, 0, 0, 0);
        route("R6 host from up", 0, HOST, 16'h0, 3'd0, DROP, 3'd0, 1, 0, 0);
        route("R6 self", 0, 64'h4800, 16'h0, 3'd1, DROP, 3'd0, 1, 0, 0);
        route("R7 miss from up", 0, 64'h3000_0000, 16'h0, 3'd0, DROP, 3'd0, 0, 1, 0);
    endtask

    task automatic t_ident;
        route("R2 R4 id overlap", 1, 64'h0, 16'h0180, 3'd0, FWD, 3'd1, 0, 0, 0);
        route("R4 id port2", 1, 64'h0, 16'h0220, 3'd0, FWD, 3'd2, 0, 0, 0);
        route("R4 id ignores addr", 1, 64'h1000_0000, 16'h0250, 3'd1, FWD, 3'd2, 0, 0, 0);
        route("R7 id miss up", 1, 64'h0, 16'h0300, 3'd0, DROP, 3'd0, 0, 1, 0);
        route("R4 id miss down", 1, 64'h0, 16'h0300, 3'd3, UP, 3'd0, 0, 0, 0);
        route("R6 id self", 1, 64'h0, 16'h0120, 3'd1, DROP, 3'd0, 1, 0, 0);
    endtask

    task automatic t_access;
        set_port(1, 16'h0100, 16'h01FF, 1, 1, 0);
        set_port(3, 16'h0150, 16'h0250, 1, 0, 1);
        route("R5 block mem", 0, 64'h1000_0000, 16'h0, 3'd1, DROP, 3'd0, 0, 0, 1);
        route("R5 block id", 1, 64'h0, 16'h0220, 3'd1, DROP, 3'd0, 0, 0, 1);
        route("R5 block host ok", 0, HOST, 16'h0, 3'd1, UP, 3'd0, 0, 0, 0);
        route("R5 force mem", 0, 64'h1000_0000, 16'h0, 3'd3, UP, 3'd0, 0, 0, 0);
        route("R5 force id", 1, 64'h0, 16'h0180, 3'd3, UP, 3'd0, 0, 0, 0);
        route("R5 other port free", 0, 64'h2000_0000, 16'h0, 3'd2, FWD, 3'd3, 0, 0, 0);
        set_port(1, 16'h0100, 16'h01FF, 1, 1, 1);
        route("R5 block beats force", 0, 64'h2000_0000, 16'h0, 3'd1, DROP, 3'd0, 0, 0, 1);
        set_port(1, 16'h0100, 16'h01FF, 1, 0, 0);
        set_port(3, 16'h0150, 16'h0250, 1, 0, 0);
    endtask

    task automatic t_invalidate;
        wr(2'd2, 0, {55'd0, 1'b0, 5'd0, 3'd2});
        route("R9 window off", 0, 64'h1000_0000, 16'h0, 3'd4, UP, 3'd0, 0, 0, 0);
        route("R9 window1 still", 0, 64'h1800_0000, 16'h0, 3'd4, FWD, 3'd3, 0, 0, 0);
        set_port(1, 16'h0100, 16'h01FF, 0, 0, 0);
        route("R9 range off", 1, 64'h0, 16'h0180, 3'd0, FWD, 3'd3, 0, 0, 0);
    endtask

    task automatic t_hold;
        @(negedge clk);
        dec_ready = 1'b0;
        route("R8 stall first", 0, 64'h4800, 16'h0, 3'd2, FWD, 3'd1, 0, 0, 0);
        check("R8 stall ready low", 32'(hdr_ready), 32'd0);
        hdr_valid = 1'b1; hdr_kind = 0; hdr_addr = 64'h3000_0000; hdr_port = 3'd0;
        @(negedge clk);
        @(negedge clk);
        check("R8 held valid", 32'(dec_valid), 32'd1);
        check("R8 held verdict", 32'(dec_verdict), 32'(FWD));
        check("R8 held port", 32'(dec_port), 32'd1);
        hdr_valid = 1'b0;
        dec_ready = 1'b1;
        @(negedge clk);
        check("R8 released", 32'(dec_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_config();
        t_address();
        t_ident();
        t_access();
        t_invalidate();
        t_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule